// File: doc/BRIEF.md
# Next-Fit Page Run Allocator

This block hands out contiguous runs of slots from a remap table of `NUM_SLOTS` entries, tracked as one occupancy bit per slot. An allocation asks for a run length. The block scans the occupancy bits one slot per cycle, starting from a rotating search pointer. It returns either the first index of a free run that fits, or a failure. A release names a start index and a length, and clears those slots.

The block also keeps a single "flush needed" flag for a downstream translation cache. Reusing a slot that was once handed out is only safe after that cache has been flushed. The flag is raised in three cases: the search wraps back to the bottom of the table, the pointer runs off the top, or an always-flush mode is selected. A flush-done pulse lowers the flag. The lowest `RESERVED` slots stay occupied from reset onward and act as an emergency reserve that is never granted.

Requests are accepted only while the block is idle. A requester waits for `busy` to drop and then samples the one-cycle response.

Top module: `nfa_run_alloc`

## Requirements
- R1: After reset, `busy`, `resp_valid` and `flush_needed` are 0. Slots 0 to `RESERVED-1` (32 by default) are occupied and are never returned. A release that covers them leaves them occupied.
- R2: The first search pass covers slots from the search pointer up to `NUM_SLOTS-1`. It returns the lowest start at or above the pointer whose whole run fits below `NUM_SLOTS`. A run never wraps past the top slot. The pointer is 0 after reset.
- R3: If the first pass finds no run, `flush_needed` is set and a second pass scans the whole table starting from slot 0.
- R4: A successful allocation gives a one-cycle `resp_valid` with `resp_ok`=1 and `resp_start` = run start. It marks the run occupied and moves the pointer to start+length.
- R5: When start+length reaches `NUM_SLOTS`, the pointer becomes 0 and `flush_needed` is set.
- R6: If both passes fail, `resp_ok`=0, `resp_start` is all ones, and no occupancy bit changes.
- R7: While `always_flush`=1, every completed allocation sets `flush_needed`, whether it succeeds or fails.
- R8: A release clears the occupancy bits of slots start to start+length-1 that lie inside the table and above the reserve. It leaves the pointer and `flush_needed` unchanged.
- R9: A `flush_done` pulse clears `flush_needed`. If a flag-setting event happens in the same cycle, the flag stays set.
- R10: `busy` is 1 from the cycle after an allocation is accepted until the response cycle. Requests are accepted only while `busy` is 0.
- R11: An allocation of length 0, or of a length larger than any free run, ends in the failure response of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| always_flush | input | 1 | When 1, every allocation raises the flush flag |
| alloc_req | input | 1 | Allocation request, taken while not busy |
| alloc_len | input | LW | Requested run length in slots |
| free_req | input | 1 | Release request, taken while not busy |
| free_start | input | IW | First slot to release |
| free_len | input | LW | Number of slots to release |
| flush_done | input | 1 | Downstream cache flush complete |
| busy | output | 1 | Scan in progress |
| resp_valid | output | 1 | One-cycle allocation response strobe |
| resp_ok | output | 1 | 1 = run granted, 0 = failure |
| resp_start | output | IW | Granted start slot, all ones on failure |
| flush_needed | output | 1 | Downstream cache must be flushed before reuse |

## Verification
The risky overlap is a `flush_done` pulse landing in the same cycle as an allocation that raises the flag. That can be a wrap, a failed first pass, or an always-flush completion. The bench provokes this by holding `flush_done` high through an entire always-flush allocation against a full table, so the final flag-setting edge coincides with a clear request. It then checks that the flag reads 1 right after the response and is still 1 one cycle after `flush_done` is released.

// File: rtl/nfa_pkg.sv
`timescale 1ns/1ps
package nfa_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_state_t;
endpackage

// File: rtl/nfa_slot_map.sv
`timescale 1ns/1ps
module nfa_slot_map #(
  parameter int NUM_SLOTS = 128,
  parameter int RESERVED  = 32,
  parameter int IW        = 7,
  parameter int LW        = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_en,
  input  logic [IW-1:0]        set_start,
  input  logic [LW-1:0]        set_len,
  input  logic                 clr_en,
  input  logic [IW-1:0]        clr_start,
  input  logic [LW-1:0]        clr_len,
  output logic [NUM_SLOTS-1:0] slot_map
);
  localparam int EW = LW + 1;
  localparam logic [NUM_SLOTS-1:0] RES_MASK =
    {{(NUM_SLOTS-RESERVED){1'b0}}, {RESERVED{1'b1}}};

  logic [EW-1:0]        set_end, clr_end;
  logic [NUM_SLOTS-1:0] set_mask, clr_mask, map_nx;

  assign set_end = EW'(set_start) + EW'(set_len);
  assign clr_end = EW'(clr_start) + EW'(clr_len);

  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      set_mask[i] = set_en && (EW'(i) >= EW'(set_start)) && (EW'(i) < set_end);
      clr_mask[i] = clr_en && (i >= RESERVED) &&
                    (EW'(i) >= EW'(clr_start)) && (EW'(i) < clr_end);
    end
    map_nx = (slot_map & ~clr_mask) | set_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                slot_map <= RES_MASK;
    else if (set_en || clr_en) slot_map <= map_nx;
  end

  // R1: the emergency reserve stays occupied
  a_r1_reserve_kept: assert property (@(posedge clk) disable iff (!rst_n)
    &slot_map[RESERVED-1:0]);
endmodule

// File: rtl/nfa_flush_flag.sv
`timescale 1ns/1ps
module nfa_flush_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic flag
);
  logic flag_nx;

  always_comb begin
    flag_nx = flag;
    if (set_req)      flag_nx = 1'b1;
    else if (clr_req) flag_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_nx;
  end

  // R9: a set in the same cycle as a clear wins
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_req |=> flag);
  a_r9_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_req) |=> !flag);
endmodule

// File: rtl/nfa_scanner.sv
`timescale 1ns/1ps
module nfa_scanner
  import nfa_pkg::*;
#(
  parameter int NUM_SLOTS = 128,
  parameter int RESERVED  = 32,
  parameter int IW        = 7,
  parameter int LW        = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_req,
  input  logic [LW-1:0]        req_len,
  input  logic [NUM_SLOTS-1:0] slot_map,
  input  logic                 always_flush,
  output logic                 busy,
  output logic                 resp_valid,
  output logic                 resp_ok,
  output logic [IW-1:0]        resp_start,
  output logic                 commit_en,
  output logic [IW-1:0]        commit_start,
  output logic [LW-1:0]        commit_len,
  output logic                 flag_set
);
  localparam int EW = LW + 1;

  scan_state_t   state, state_nx;
  logic [IW-1:0] cursor, cursor_nx, next_ptr, ptr_nx;
  logic [LW-1:0] run_cnt, cnt_nx, len_q, len_nx, cnt_inc;
  logic          pass_q, pass_nx;
  logic          rv_nx, rok_nx;
  logic [IW-1:0] rstart_nx, hit_start;
  logic [EW-1:0] run_end;
  logic          slot_free, hit, at_end, wrap;

  assign busy      = (state == ST_SCAN);
  assign slot_free = !slot_map[cursor];
  assign cnt_inc   = run_cnt + LW'(1);
  assign hit       = busy && slot_free && (cnt_inc == len_q);
  assign at_end    = (cursor == IW'(NUM_SLOTS-1));
  assign hit_start = cursor - IW'(len_q) + IW'(1);
  assign run_end   = EW'(hit_start) + EW'(len_q);
  assign wrap      = (run_end >= EW'(NUM_SLOTS));

  assign commit_en    = hit;
  assign commit_start = hit_start;
  assign commit_len   = len_q;

  always_comb begin
    state_nx  = state;
    cursor_nx = cursor;
    cnt_nx    = run_cnt;
    len_nx    = len_q;
    pass_nx   = pass_q;
    ptr_nx    = next_ptr;
    rv_nx     = 1'b0;
    rok_nx    = resp_ok;
    rstart_nx = resp_start;
    flag_set  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start_req) begin
          state_nx  = ST_SCAN;
          cursor_nx = next_ptr;
          cnt_nx    = '0;
          len_nx    = req_len;
          pass_nx   = 1'b0;
        end
      end
      ST_SCAN: begin
        if (hit) begin
          state_nx  = ST_IDLE;
          rv_nx     = 1'b1;
          rok_nx    = 1'b1;
          rstart_nx = hit_start;
          ptr_nx    = wrap ? '0 : IW'(run_end);
          flag_set  = wrap || always_flush;
        end else if (at_end) begin
          cnt_nx = '0;
          if (!pass_q) begin
            cursor_nx = '0;
            pass_nx   = 1'b1;
            flag_set  = 1'b1;
          end else begin
            state_nx  = ST_IDLE;
            rv_nx     = 1'b1;
            rok_nx    = 1'b0;
            rstart_nx = '1;
            flag_set  = always_flush;
          end
        end else begin
          cursor_nx = cursor + IW'(1);
          cnt_nx    = slot_free ? cnt_inc : '0;
        end
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cursor   <= '0;
      run_cnt  <= '0;
      len_q    <= '0;
      pass_q   <= 1'b0;
      next_ptr <= '0;
    end else if (busy || start_req) begin
      state    <= state_nx;
      cursor   <= cursor_nx;
      run_cnt  <= cnt_nx;
      len_q    <= len_nx;
      pass_q   <= pass_nx;
      next_ptr <= ptr_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_ok    <= 1'b0;
      resp_start <= '0;
    end else begin
      resp_valid <= rv_nx;
      resp_ok    <= rok_nx;
      resp_start <= rstart_nx;
    end
  end

  // R6: failure reports an all-ones index
  a_r6_fail_index: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ok) |-> (resp_start == '1));
  // R1: never grant inside the reserve
  a_r1_no_reserve_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_ok) |-> (resp_start >= IW'(RESERVED)));
  // R2: a granted run fits below the top slot
  a_r2_run_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_ok) |-> ((EW'(resp_start) + EW'(len_q)) <= EW'(NUM_SLOTS)));
endmodule

// File: rtl/nfa_run_alloc.sv
`timescale 1ns/1ps
module nfa_run_alloc #(
  parameter int NUM_SLOTS = 128,
  parameter int RESERVED  = 32,
  parameter int IW        = $clog2(NUM_SLOTS),
  parameter int LW        = $clog2(NUM_SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          always_flush,
  input  logic          alloc_req,
  input  logic [LW-1:0] alloc_len,
  input  logic          free_req,
  input  logic [IW-1:0] free_start,
  input  logic [LW-1:0] free_len,
  input  logic          flush_done,
  output logic          busy,
  output logic          resp_valid,
  output logic          resp_ok,
  output logic [IW-1:0] resp_start,
  output logic          flush_needed
);
  logic [1:0]           rst_sync;
  logic                 core_rst_n;
  logic                 take_alloc, take_free;
  logic                 commit_en, flag_set;
  logic [IW-1:0]        commit_start;
  logic [LW-1:0]        commit_len;
  logic [NUM_SLOTS-1:0] slot_map;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  assign take_alloc = alloc_req && !busy;
  assign take_free  = free_req && !busy;

  nfa_slot_map #(.NUM_SLOTS(NUM_SLOTS), .RESERVED(RESERVED), .IW(IW), .LW(LW)) u_map (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .set_en    (commit_en),
    .set_start (commit_start),
    .set_len   (commit_len),
    .clr_en    (take_free),
    .clr_start (free_start),
    .clr_len   (free_len),
    .slot_map  (slot_map)
  );

  nfa_scanner #(.NUM_SLOTS(NUM_SLOTS), .RESERVED(RESERVED), .IW(IW), .LW(LW)) u_scan (
    .clk          (clk),
    .rst_n        (core_rst_n),
    .start_req    (take_alloc),
    .req_len      (alloc_len),
    .slot_map     (slot_map),
    .always_flush (always_flush),
    .busy         (busy),
    .resp_valid   (resp_valid),
    .resp_ok      (resp_ok),
    .resp_start   (resp_start),
    .commit_en    (commit_en),
    .commit_start (commit_start),
    .commit_len   (commit_len),
    .flag_set     (flag_set)
  );

  nfa_flush_flag u_flag (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .set_req (flag_set),
    .clr_req (flush_done),
    .flag    (flush_needed)
  );

  // R10: the response cycle leaves the block idle
  a_r10_resp_idle: assert property (@(posedge clk) disable iff (!core_rst_n)
    resp_valid |-> !busy);
  // R10: an accepted allocation makes the block busy next cycle
  a_r10_busy_after_take: assert property (@(posedge clk) disable iff (!core_rst_n)
    take_alloc |=> busy);
endmodule

// File: tb/sim_nfa_run_alloc.sv
`timescale 1ns/1ps
module sim_nfa_run_alloc;
  localparam int N  = 128;
  localparam int IW = 7;
  localparam int LW = 8;

  logic          clk = 1'b0;
  logic          rst_n, always_flush, alloc_req, free_req, flush_done;
  logic [LW-1:0] alloc_len, free_len;
  logic [IW-1:0] free_start;
  logic          busy, resp_valid, resp_ok, flush_needed;
  logic [IW-1:0] resp_start;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  nfa_run_alloc #(.NUM_SLOTS(N), .RESERVED(32)) u0 (
    .clk(clk), .rst_n(rst_n), .always_flush(always_flush),
    .alloc_req(alloc_req), .alloc_len(alloc_len),
    .free_req(free_req), .free_start(free_start), .free_len(free_len),
    .flush_done(flush_done), .busy(busy), .resp_valid(resp_valid),
    .resp_ok(resp_ok), .resp_start(resp_start), .flush_needed(flush_needed)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_alloc(input int len, input bit exp_ok, input int exp_start,
                          input bit exp_flag, input string tag);
    bit got = 1'b0;
    @(negedge clk);
    alloc_req = 1'b1;
    alloc_len = LW'(len);
    @(negedge clk);
    alloc_req = 1'b0;
    for (int k = 0; k < 1000 && !got; k++) begin
      @(negedge clk);
      if (resp_valid) got = 1'b1;
    end
    check(got, {tag, " response"}, int'(got), 1);
    check(resp_ok == exp_ok, {tag, " ok"}, int'(resp_ok), int'(exp_ok));
    check(int'(resp_start) == exp_start, {tag, " start"}, int'(resp_start), exp_start);
    check(flush_needed == exp_flag, {tag, " flag"}, int'(flush_needed), int'(exp_flag));
  endtask

  task automatic do_free(input int start, input int len);
    @(negedge clk);
    free_req   = 1'b1;
    free_start = IW'(start);
    free_len   = LW'(len);
    @(negedge clk);
    free_req   = 1'b0;
  endtask

  task automatic pulse_flush();
    @(negedge clk);
    flush_done = 1'b1;
    @(negedge clk);
    flush_done = 1'b0;
    @(negedge clk);
    check(!flush_needed, "R9 flush_done clears", int'(flush_needed), 0);
  endtask

  task automatic t_reset();
    check(!busy, "R1 busy after reset", int'(busy), 0);
    check(!resp_valid, "R1 resp_valid after reset", int'(resp_valid), 0);
    check(!flush_needed, "R1 flag after reset", int'(flush_needed), 0);
  endtask

  task automatic t_first_alloc_busy();
    @(negedge clk);
    alloc_req = 1'b1;
    alloc_len = LW'(4);
    @(negedge clk);
    alloc_req = 1'b0;
    check(busy, "R10 busy after accept", int'(busy), 1);
    while (!resp_valid) @(negedge clk);
    check(resp_ok && resp_start == 7'd32, "R4 first grant at 32", int'(resp_start), 32);
    check(!busy, "R10 idle at response", int'(busy), 0);
  endtask

  task automatic t_next_fit();
    do_alloc(8, 1'b1, 36, 1'b0, "R4 second grant");
    do_free(32, 4);
    check(!flush_needed, "R8 free leaves flag", int'(flush_needed), 0);
    do_alloc(4, 1'b1, 44, 1'b0, "R2 next-fit skips freed 32");
  endtask

  task automatic t_always_flush();
    always_flush = 1'b1;
    do_alloc(2, 1'b1, 48, 1'b1, "R7 always-flush grant");
    always_flush = 1'b0;
    pulse_flush();
  endtask

  task automatic t_wrap_exact();
    do_alloc(78, 1'b1, 50, 1'b1, "R5 run ends at top");
    pulse_flush();
    do_alloc(4, 1'b1, 32, 1'b0, "R5 pointer wrapped to 0");
  endtask

  task automatic t_fail_keeps_map();
    do_free(60, 10);
    do_alloc(20, 1'b0, 127, 1'b1, "R6 both passes fail");
    pulse_flush();
    do_alloc(10, 1'b1, 60, 1'b0, "R6 map unchanged after fail");
  endtask

  task automatic t_retry_from_zero();
    do_free(40, 4);
    do_alloc(4, 1'b1, 40, 1'b1, "R3 retry from 0 after miss");
    pulse_flush();
  endtask

  task automatic t_reserve();
    do_free(0, 32);
    do_alloc(1, 1'b0, 127, 1'b1, "R1 reserve not released");
    pulse_flush();
  endtask

  task automatic t_zero_len();
    do_alloc(0, 1'b0, 127, 1'b1, "R11 zero length fails");
    pulse_flush();
  endtask

  task automatic t_set_vs_clear();
    always_flush = 1'b1;
    @(negedge clk);
    flush_done = 1'b1;
    do_alloc(1, 1'b0, 127, 1'b1, "R9 set wins over clear");
    flush_done = 1'b0;
    always_flush = 1'b0;
    @(negedge clk);
    check(flush_needed, "R9 flag held after clear drops", int'(flush_needed), 1);
    pulse_flush();
  endtask

  task automatic t_free_past_top();
    do_free(120, 20);
    do_alloc(8, 1'b1, 120, 1'b1, "R8 clipped free then R5 wrap");
  endtask

  initial begin
    #1500000;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; always_flush = 1'b0; alloc_req = 1'b0; free_req = 1'b0;
    flush_done = 1'b0; alloc_len = '0; free_len = '0; free_start = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_first_alloc_busy();
    t_next_fit();
    t_always_flush();
    t_wrap_exact();
    t_fail_keeps_map();
    t_retry_from_zero();
    t_reserve();
    t_zero_len();
    t_set_vs_clear();
    t_free_past_top();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule